// File: doc/BRIEF.md
# Instruction Fan-out Loader for a Tiled Processing Array

This block sits on the chip-wide loading network of an 8 by 8 array of processing elements, each of which owns a small store of activation frames. It takes one loading command at a time and turns it into a single-cycle write towards the array. A command carries a loading mode, a 6-bit element address, a 64-bit selection mask, a frame index and an instruction word. The block then drives one write-enable line per element, together with a frame index bus and an instruction bus that all the elements share.

Three loading patterns are supported. The first writes one addressed element. The second writes every element in the same cycle. The third writes only the elements whose mask bit is set. A fourth mode code is illegal, and the block answers it with an error pulse instead of a write. A data-flow graph loader uses the block to place a program into the array. It uses the addressed mode for irregular placement, the all-element mode for code that every element shares, and the mask mode for code that only a set of elements needs.

Top module: `frame_map_dist`

## Requirements
- R1: After reset `cmdReady` is 1, every bit of `peWrEn` is 0, and `doneP` and `errP` are 0.
- R2: A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both 1. In the cycle that follows acceptance `cmdReady` is 0.
- R3: Mode 2'b00 (single element) sets exactly one bit of `peWrEn`, at index `cmdTarget`. Bits [5:3] of `cmdTarget` give the row and bits [2:0] give the column, so the index is row*8+column.
- R4: Mode 2'b01 (all elements) sets all 64 bits of `peWrEn`.
- R5: Mode 2'b10 (masked) makes `peWrEn` equal to `cmdMask`. Mask bit i selects the element at row i/8 and column i%8.
- R6: The write enables are high only in the one cycle right after acceptance, and they are zero in the cycle after that.
- R7: In the write cycle, `wrFrame` and `wrInstr` hold the frame index and instruction word of the accepted command.
- R8: `doneP` is high for one cycle, in the cycle right after the write cycle. `cmdReady` is 1 in that cycle, so a new command can be accepted there.
- R9: Masked mode with an all-zero mask sets no write enable, and `doneP` still follows on schedule.
- R10: Mode 2'b11 sets no write enable and raises no `doneP`. It raises `errP` for one cycle in the cycle after acceptance, and `cmdReady` returns to 1 in the cycle after that.
- R11: A command accepted in the `doneP` cycle is handled in full, with its own write cycle following at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | The block can take a command |
| cmdMode | input | 2 | Loading mode: 00 single, 01 all, 10 masked, 11 illegal |
| cmdTarget | input | 6 | Element address {row, column}, used in single mode |
| cmdMask | input | 64 | Element selection, used in masked mode |
| cmdFrame | input | 4 | Activation frame index |
| cmdInstr | input | 32 | Instruction word |
| peWrEn | output | 64 | Write enable, one bit per element |
| wrFrame | output | 4 | Frame index shared by all elements |
| wrInstr | output | 32 | Instruction word shared by all elements |
| doneP | output | 1 | Command completed |
| errP | output | 1 | Illegal mode rejected |

## Verification
The hardest case to reach from the ports is a command accepted during the completion cycle of the previous one. The write stage of the new command must then start while the old done pulse is still ending, and its enables must not mix with the old ones. The stimulus gets there by leaving the valid line high straight after a completion is sampled, so the next command lands in the done cycle. The second command uses a different mode and different data from the first. The illegal code and the empty mask are also placed next to legal commands, to show that neither one leaks enables into the command next to it.

// File: rtl/frame_map_pkg.sv
package frame_map_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_ALL    = 2'b01,
    MODE_MASKED = 2'b10,
    MODE_BAD    = 2'b11
  } mapMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01,
    ST_DONE  = 2'b10,
    ST_ERR   = 2'b11
  } mapState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;   // capture frame index and instruction
    logic loadEn;    // capture the enable pattern (else clear)
  } mapStrobe_t;

endpackage

// File: rtl/fmd_addr_decoder.sv
module fmd_addr_decoder #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int PE_N   = ROWS * COLS,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PE_N-1:0]   oneHot
);

  logic [ROW_W-1:0] rowSel;
  logic [COL_W-1:0] colSel;

  assign rowSel = addr[ADDR_W-1:COL_W];
  assign colSel = addr[COL_W-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign oneHot[r*COLS + c] = (rowSel == ROW_W'(r)) && (colSel == COL_W'(c));
    end
  end

endmodule

// File: rtl/fmd_datapath.sv
module fmd_datapath
  import frame_map_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int FRAME_W = 4,
  parameter int INSTR_W = 32,
  localparam int PE_N   = ROWS * COLS,
  localparam int ADDR_W = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         strobe,
  input  logic [1:0]         cmdMode,
  input  logic [ADDR_W-1:0]  cmdTarget,
  input  logic [PE_N-1:0]    cmdMask,
  input  logic [FRAME_W-1:0] cmdFrame,
  input  logic [INSTR_W-1:0] cmdInstr,
  output logic [PE_N-1:0]    peWrEn,
  output logic [FRAME_W-1:0] wrFrame,
  output logic [INSTR_W-1:0] wrInstr
);

  logic [PE_N-1:0] singleHot;
  logic [PE_N-1:0] enNext;

  fmd_addr_decoder #(.ROWS(ROWS), .COLS(COLS)) dec_i (
    .addr  (cmdTarget),
    .oneHot(singleHot)
  );

  always_comb begin
    unique case (mapMode_e'(cmdMode))
      MODE_SINGLE: enNext = singleHot;
      MODE_ALL:    enNext = '1;
      MODE_MASKED: enNext = cmdMask;
      default:     enNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peWrEn <= '0;
    end else if (strobe.loadEn) begin
      peWrEn <= enNext;
    end else begin
      peWrEn <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFrame <= '0;
      wrInstr <= '0;
    end else if (strobe.loadCmd) begin
      wrFrame <= cmdFrame;
      wrInstr <= cmdInstr;
    end
  end

endmodule

// File: rtl/fmd_control.sv
module fmd_control
  import frame_map_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdMode,
  output logic       cmdReady,
  output mapStrobe_t strobe,
  output logic       doneP,
  output logic       errP
);

  mapState_e state, stateNext;
  logic      accept;
  logic      legal;

  assign cmdReady = (state == ST_IDLE) || (state == ST_DONE);
  assign accept   = cmdValid && cmdReady;
  assign legal    = mapMode_e'(cmdMode) != MODE_BAD;

  assign strobe.loadCmd = accept && legal;
  assign strobe.loadEn  = accept && legal;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (accept) stateNext = legal ? ST_WRITE : ST_ERR;
        else        stateNext = ST_IDLE;
      end
      ST_WRITE: stateNext = ST_DONE;
      ST_ERR:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign doneP = (state == ST_DONE);
  assign errP  = (state == ST_ERR);

endmodule

// File: rtl/frame_map_dist.sv
module frame_map_dist
  import frame_map_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int FRAME_W = 4,
  parameter int INSTR_W = 32,
  localparam int PE_N   = ROWS * COLS,
  localparam int ADDR_W = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdMode,
  input  logic [ADDR_W-1:0]  cmdTarget,
  input  logic [PE_N-1:0]    cmdMask,
  input  logic [FRAME_W-1:0] cmdFrame,
  input  logic [INSTR_W-1:0] cmdInstr,
  output logic [PE_N-1:0]    peWrEn,
  output logic [FRAME_W-1:0] wrFrame,
  output logic [INSTR_W-1:0] wrInstr,
  output logic               doneP,
  output logic               errP
);

  mapStrobe_t strobe;

  fmd_control ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdMode (cmdMode),
    .cmdReady(cmdReady),
    .strobe  (strobe),
    .doneP   (doneP),
    .errP    (errP)
  );

  fmd_datapath #(
    .ROWS(ROWS), .COLS(COLS), .FRAME_W(FRAME_W), .INSTR_W(INSTR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdMode  (cmdMode),
    .cmdTarget(cmdTarget),
    .cmdMask  (cmdMask),
    .cmdFrame (cmdFrame),
    .cmdInstr (cmdInstr),
    .peWrEn   (peWrEn),
    .wrFrame  (wrFrame),
    .wrInstr  (wrInstr)
  );

endmodule

// File: rtl/frame_map_dist_chk.sv
module frame_map_dist_chk #(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int FRAME_W = 4,
  parameter int INSTR_W = 32,
  localparam int PE_N   = ROWS * COLS,
  localparam int ADDR_W = $clog2(ROWS) + $clog2(COLS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [1:0]         cmdMode,
  input logic [ADDR_W-1:0]  cmdTarget,
  input logic [PE_N-1:0]    cmdMask,
  input logic [FRAME_W-1:0] cmdFrame,
  input logic [INSTR_W-1:0] cmdInstr,
  input logic [PE_N-1:0]    peWrEn,
  input logic [FRAME_W-1:0] wrFrame,
  input logic [INSTR_W-1:0] wrInstr,
  input logic               doneP,
  input logic               errP
);

  logic acc;
  assign acc = cmdValid && cmdReady;

  // R2
  no_ready_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> !cmdReady);

  // R3
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode == 2'b00) |=> peWrEn == (PE_N'(1) << $past(cmdTarget)));

  // R4
  all_elements_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode == 2'b01) |=> &peWrEn);

  // R5
  mask_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode == 2'b10) |=> peWrEn == $past(cmdMask));

  // R6
  enable_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (peWrEn != '0) |=> peWrEn == '0);

  // R7
  bus_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode != 2'b11) |=> (wrFrame == $past(cmdFrame)) && (wrInstr == $past(cmdInstr)));

  // R8
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode != 2'b11) |=> ##1 (doneP && cmdReady));

  // R10
  error_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdMode == 2'b11) |=> (errP && !doneP && peWrEn == '0));

  // R10
  error_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errP) |-> $past(acc && cmdMode == 2'b11));

endmodule

bind frame_map_dist frame_map_dist_chk #(
  .ROWS(ROWS), .COLS(COLS), .FRAME_W(FRAME_W), .INSTR_W(INSTR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdMode  (cmdMode),
  .cmdTarget(cmdTarget),
  .cmdMask  (cmdMask),
  .cmdFrame (cmdFrame),
  .cmdInstr (cmdInstr),
  .peWrEn   (peWrEn),
  .wrFrame  (wrFrame),
  .wrInstr  (wrInstr),
  .doneP    (doneP),
  .errP     (errP)
);

// File: tb/frame_map_dist_tb_top.sv
module frame_map_dist_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdMode = '0;
  logic [5:0]  cmdTarget = '0;
  logic [63:0] cmdMask = '0;
  logic [3:0]  cmdFrame = '0;
  logic [31:0] cmdInstr = '0;
  logic [63:0] peWrEn;
  logic [3:0]  wrFrame;
  logic [31:0] wrInstr;
  logic        doneP;
  logic        errP;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_map_dist dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdMode(cmdMode), .cmdTarget(cmdTarget), .cmdMask(cmdMask),
    .cmdFrame(cmdFrame), .cmdInstr(cmdInstr), .peWrEn(peWrEn),
    .wrFrame(wrFrame), .wrInstr(wrInstr), .doneP(doneP), .errP(errP)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge with cmdReady expected high; returns at the
  // falling edge of the completion cycle (or the cycle after an error).
  task automatic issue(input string req, input logic [1:0] mode, input logic [5:0] tgt,
                       input logic [63:0] mask, input logic [3:0] frm, input logic [31:0] ins);
    logic [63:0] expEn;
    bit          bad;
    bad = (mode == 2'b11);
    case (mode)
      2'b00:   expEn = 64'd1 << tgt;
      2'b01:   expEn = '1;
      2'b10:   expEn = mask;
      default: expEn = '0;
    endcase
    cmdValid = 1'b1; cmdMode = mode; cmdTarget = tgt; cmdMask = mask;
    cmdFrame = frm; cmdInstr = ins;
    check({req, " R2 ready before accept"}, 64'(cmdReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check({req, " R2 ready low after accept"}, 64'(cmdReady), 64'd0);
    check({req, " enables"}, peWrEn, expEn);
    if (!bad) begin
      check({req, " R7 frame"}, 64'(wrFrame), 64'(frm));
      check({req, " R7 instr"}, 64'(wrInstr), 64'(ins));
      check({req, " R8 no early done"}, 64'(doneP), 64'd0);
    end else begin
      check({req, " R10 error pulse"}, 64'(errP), 64'd1);
      check({req, " R10 no done"}, 64'(doneP), 64'd0);
    end
    @(negedge clk);
    check({req, " R6 enables cleared"}, peWrEn, 64'd0);
    check({req, " R8 done pulse"}, 64'(doneP), 64'(!bad));
    check({req, " R10 error single"}, 64'(errP), 64'd0);
    check({req, " R8 ready again"}, 64'(cmdReady), 64'd1);
  endtask

  task automatic t_reset();
    check("R1 ready", 64'(cmdReady), 64'd1);
    check("R1 enables", peWrEn, 64'd0);
    check("R1 done", 64'(doneP), 64'd0);
    check("R1 err", 64'(errP), 64'd0);
  endtask

  task automatic t_single();
    issue("R3 corner 0",  2'b00, 6'd0,  '0, 4'h1, 32'h1111_0001);
    @(negedge clk);
    issue("R3 row7 col7", 2'b00, 6'd63, '0, 4'h2, 32'h2222_0002);
    issue("R3 row2 col5", 2'b00, {3'd2, 3'd5}, 64'hFFFF, 4'h3, 32'h3333_0003);
    @(negedge clk);
    check("R6 idle no enables", peWrEn, 64'd0);
  endtask

  task automatic t_all();
    issue("R4 broadcast", 2'b01, 6'd9, 64'h0, 4'hA, 32'hDEAD_BEEF);
    @(negedge clk);
  endtask

  task automatic t_mask();
    issue("R5 checker",  2'b10, 6'd0, 64'hAA55_AA55_0F0F_8001, 4'h5, 32'hCAFE_0005);
    issue("R5 one bit",  2'b10, 6'd0, 64'h8000_0000_0000_0000, 4'h6, 32'hCAFE_0006);
    issue("R9 empty",    2'b10, 6'd7, 64'h0, 4'h7, 32'hCAFE_0007);
    @(negedge clk);
  endtask

  task automatic t_error();
    issue("R10 bad mode", 2'b11, 6'd3, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 32'hBAD0_BAD0);
    check("R10 no stray enables", peWrEn, 64'd0);
    issue("R10 recover", 2'b00, 6'd17, '0, 4'h8, 32'h0000_0017);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    issue("R11 first",  2'b01, 6'd0, '0, 4'h9, 32'hAAAA_0001);
    issue("R11 second", 2'b00, 6'd42, '0, 4'hB, 32'hBBBB_0002);
    issue("R11 third",  2'b10, 6'd0, 64'h0000_00F0_0000_0000, 4'hC, 32'hCCCC_0003);
    issue("R11 error",  2'b11, 6'd0, '0, 4'hD, 32'hDDDD_0004);
    issue("R11 after",  2'b00, 6'd8, '0, 4'hE, 32'hEEEE_0005);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_all();
    t_mask();
    t_error();
    t_back_to_back();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule